// File: doc/BRIEF.md
# Write-Through Snooping Invalidate Cache Cluster

This block is a group of small direct-mapped processor caches that share one bus and one word-addressed memory. Coherence works by write-through with invalidation. Each cache line holds a single word, and that word is the same width as a processor access. A line is either not present or present. A present line always equals memory, and several caches may hold the same address at once.

A read that hits is answered locally and puts nothing on the bus. A read that misses performs one bus read and installs the word it gets back. Every write updates the writer's own line, allocating the line without a fill when it was absent, and places a write on the bus that updates memory. Every other cache watches those bus writes. A cache drops its copy only when the written address matches both the set and the stored tag.

A fixed-priority arbiter serialises the bus, and each bus transaction completes in the cycle it is granted. A request that needs the bus stalls its processor port until its grant arrives.

Top module: `wt_snoop_cluster`

## Requirements
- R1: After reset every line of every cache is absent (all `line_valid_o` bits 0), every `req_ready_o` bit is 1, no `rsp_valid_o` bit is set, and memory reads as zero.
- R2: A read miss causes exactly one bus read of the requested address. One cycle after the grant, the response carries the memory word and the line becomes present.
- R3: A read that hits a present line with a matching tag is answered one cycle after acceptance with the cached word. It causes no bus transaction, and the line stays present.
- R4: Every accepted write causes exactly one bus write of its address and data, which updates memory. The writer's line is present afterwards, whether the write hit or missed. A write miss performs no fill read. A write's response returns the written data.
- R5: A bus write by one cache clears the line in every other cache whose set and stored tag match the written address. When no other cache holds that address, no line changes.
- R6: A bus write whose address maps to a set holding a different tag leaves that line present, and a later read of the stored address still hits.
- R7: A read miss into a set holding a different present tag replaces that line without any write-back, using exactly one bus read.
- R8: When several caches request the bus in the same cycle, the lowest-numbered cache is granted first, at most one grant is active per cycle, and caches still waiting keep `req_ready_o` low.
- R9: The set index is address bit 0 and the tag is the remaining upper bits. The presence of set `s` in cache `c` appears on `line_valid_o[c*2+s]`.
- R10: Each accepted request produces exactly one response pulse on its own port. `req_ready_o` is low while a bus transaction for that port is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | NCPU | Request valid, one bit per processor |
| req_ready_o | output | NCPU | Port can accept a request |
| req_we_i | input | NCPU | 1 = write, 0 = read |
| req_addr_i | input | NCPU*AW | Word address per processor, slice c*AW |
| req_wdata_i | input | NCPU*DW | Write data per processor, slice c*DW |
| rsp_valid_o | output | NCPU | One-cycle response pulse per processor |
| rsp_rdata_o | output | NCPU*DW | Read data, or echoed write data |
| line_valid_o | output | NCPU*NSETS | Presence bit of each line, index c*NSETS+set |
| bus_valid_o | output | 1 | A bus transaction occurs this cycle |
| bus_we_o | output | 1 | The current bus transaction is a write |
| bus_addr_o | output | AW | Address of the current bus transaction |

## Verification
The assertions assume that a processor holds its request fields stable while `req_valid_i` is high and `req_ready_o` is low. They also assume that a cache is the only source that writes memory. The bench drives each port through one task that obeys the handshake, and memory is reached only through the caches. The snoop-related checks assume that no read hit is accepted in the same cycle that another cache writes the same address. The bench therefore issues requests serially, except in one simultaneous burst that consists only of writes.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic {
    C_IDLE = 1'b0,
    C_BUS  = 1'b1
  } cache_st_e;
endpackage

// File: rtl/wt_line.sv
module wt_line #(
  parameter int TAG_W = 1,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [DW-1:0]    fill_data_i,
  input  logic             snp_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [DW-1:0]    data_o
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [DW-1:0]    data_q;
  logic             inv;

  // snooped write kills the copy only on an exact tag match
  assign inv = snp_i && valid_q && (tag_q == snp_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      data_q  <= '0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      tag_q   <= fill_tag_i;
      data_q  <= fill_data_i;
    end else if (inv) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign data_o  = data_q;
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import snoop_pkg::*;
#(
  parameter int AW    = 2,
  parameter int DW    = 8,
  parameter int IDX_W = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_we_i,
  input  logic [AW-1:0]         req_addr_i,
  input  logic [DW-1:0]         req_wdata_i,
  output logic                  rsp_valid_o,
  output logic [DW-1:0]         rsp_rdata_o,
  output logic                  bus_req_o,
  input  logic                  bus_gnt_i,
  output logic                  bus_we_o,
  output logic [AW-1:0]         bus_addr_o,
  output logic [DW-1:0]         bus_wdata_o,
  input  logic [DW-1:0]         bus_rdata_i,
  input  logic                  snp_valid_i,
  input  logic [AW-1:0]         snp_addr_i,
  output logic [(1<<IDX_W)-1:0] line_valid_o
);
  localparam int NSETS = 1 << IDX_W;
  localparam int TAG_W = AW - IDX_W;

  cache_st_e        state_q;
  logic             op_we_q;
  logic [AW-1:0]    op_addr_q;
  logic [DW-1:0]    op_wdata_q;
  logic             rsp_valid_q;
  logic [DW-1:0]    rsp_data_q;

  logic [NSETS-1:0] valid_w;
  logic [TAG_W-1:0] tag_w  [NSETS];
  logic [DW-1:0]    data_w [NSETS];

  logic [IDX_W-1:0] req_idx, op_idx, snp_idx;
  logic [TAG_W-1:0] req_tag, op_tag, snp_tag;
  logic             accept, hit, fill;
  logic [DW-1:0]    fill_data;

  assign req_idx = req_addr_i[IDX_W-1:0];
  assign req_tag = req_addr_i[AW-1:IDX_W];
  assign op_idx  = op_addr_q[IDX_W-1:0];
  assign op_tag  = op_addr_q[AW-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[AW-1:IDX_W];

  assign accept    = req_valid_i && (state_q == C_IDLE);
  assign hit       = valid_w[req_idx] && (tag_w[req_idx] == req_tag);
  assign fill      = (state_q == C_BUS) && bus_gnt_i;
  // write miss allocates without a fill read
  assign fill_data = op_we_q ? op_wdata_q : bus_rdata_i;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    wt_line #(.TAG_W(TAG_W), .DW(DW)) u_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_i      (fill && (op_idx == IDX_W'(s))),
      .fill_tag_i  (op_tag),
      .fill_data_i (fill_data),
      .snp_i       (snp_valid_i && (snp_idx == IDX_W'(s))),
      .snp_tag_i   (snp_tag),
      .valid_o     (valid_w[s]),
      .tag_o       (tag_w[s]),
      .data_o      (data_w[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= C_IDLE;
      op_we_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
    end else begin
      case (state_q)
        C_IDLE: if (accept && (req_we_i || !hit)) begin
          state_q    <= C_BUS;
          op_we_q    <= req_we_i;
          op_addr_q  <= req_addr_i;
          op_wdata_q <= req_wdata_i;
        end
        C_BUS: if (bus_gnt_i) state_q <= C_IDLE;
        default: state_q <= C_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= fill || (accept && !req_we_i && hit);
      if (fill)       rsp_data_q <= fill_data;
      else if (accept) rsp_data_q <= data_w[req_idx];
    end
  end

  assign req_ready_o  = (state_q == C_IDLE);
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_rdata_o  = rsp_data_q;
  assign bus_req_o    = (state_q == C_BUS);
  assign bus_we_o     = op_we_q;
  assign bus_addr_o   = op_addr_q;
  assign bus_wdata_o  = op_wdata_q;
  assign line_valid_o = valid_w;
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // fixed priority, index 0 highest
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !taken) begin
        gnt_o[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/word_mem.sv
module word_mem #(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/wt_snoop_cluster.sv
module wt_snoop_cluster #(
  parameter int NCPU  = 3,
  parameter int AW    = 2,
  parameter int DW    = 8,
  parameter int IDX_W = 1,
  localparam int NSETS = 1 << IDX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCPU-1:0]       req_valid_i,
  output logic [NCPU-1:0]       req_ready_o,
  input  logic [NCPU-1:0]       req_we_i,
  input  logic [NCPU*AW-1:0]    req_addr_i,
  input  logic [NCPU*DW-1:0]    req_wdata_i,
  output logic [NCPU-1:0]       rsp_valid_o,
  output logic [NCPU*DW-1:0]    rsp_rdata_o,
  output logic [NCPU*NSETS-1:0] line_valid_o,
  output logic                  bus_valid_o,
  output logic                  bus_we_o,
  output logic [AW-1:0]         bus_addr_o
);
  logic [NCPU-1:0] bus_req, bus_gnt;
  logic [NCPU-1:0] c_we;
  logic [AW-1:0]   c_addr  [NCPU];
  logic [DW-1:0]   c_wdata [NCPU];
  logic [DW-1:0]   bus_wdata, bus_rdata;
  logic            bus_valid, bus_we;
  logic [AW-1:0]   bus_addr;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    wt_cache #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_cache (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_valid_i  (req_valid_i[c]),
      .req_ready_o  (req_ready_o[c]),
      .req_we_i     (req_we_i[c]),
      .req_addr_i   (req_addr_i[c*AW +: AW]),
      .req_wdata_i  (req_wdata_i[c*DW +: DW]),
      .rsp_valid_o  (rsp_valid_o[c]),
      .rsp_rdata_o  (rsp_rdata_o[c*DW +: DW]),
      .bus_req_o    (bus_req[c]),
      .bus_gnt_i    (bus_gnt[c]),
      .bus_we_o     (c_we[c]),
      .bus_addr_o   (c_addr[c]),
      .bus_wdata_o  (c_wdata[c]),
      .bus_rdata_i  (bus_rdata),
      .snp_valid_i  (bus_valid && bus_we && !bus_gnt[c]),
      .snp_addr_i   (bus_addr),
      .line_valid_o (line_valid_o[c*NSETS +: NSETS])
    );
  end

  bus_arbiter #(.N(NCPU)) u_arb (
    .req_i (bus_req),
    .gnt_o (bus_gnt)
  );

  // one-hot grant selects the bus driver
  always_comb begin
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (bus_gnt[c]) begin
        bus_we    = bus_we    | c_we[c];
        bus_addr  = bus_addr  | c_addr[c];
        bus_wdata = bus_wdata | c_wdata[c];
      end
    end
  end
  assign bus_valid = |bus_gnt;

  word_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_valid && bus_we),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .rdata_o (bus_rdata)
  );

  assign bus_valid_o = bus_valid;
  assign bus_we_o    = bus_we;
  assign bus_addr_o  = bus_addr;
endmodule

// File: rtl/wt_snoop_cluster_chk.sv
module wt_snoop_cluster_chk #(
  parameter int NCPU  = 3,
  parameter int AW    = 2,
  parameter int NSETS = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NCPU-1:0]       gnt_i,
  input logic [NCPU-1:0]       req_ready_i,
  input logic [NCPU-1:0]       rsp_valid_i,
  input logic [NCPU*NSETS-1:0] line_valid_i,
  input logic                  bus_valid_i,
  input logic                  bus_we_i,
  input logic [AW-1:0]         bus_addr_i
);
  localparam int IDX_W = $clog2(NSETS);

  logic [IDX_W-1:0] last_set_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_set_q <= '0;
    else         last_set_q <= bus_addr_i[IDX_W-1:0];
  end

  // R8
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));

  for (genvar k = 0; k < NCPU; k++) begin : g_k
    // R10
    busy_while_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_i[k] |-> !req_ready_i[k]);
    // R2
    grant_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_i[k] |=> rsp_valid_i[k]);
    // R4
    writer_keeps_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_i[k] && bus_we_i) |=> line_valid_i[k*NSETS + int'(last_set_q)]);
  end

  for (genvar i = 0; i < NCPU*NSETS; i++) begin : g_line
    // R5
    inv_needs_bus_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(line_valid_i[i]) |-> $past(bus_valid_i && bus_we_i));
  end
endmodule

bind wt_snoop_cluster wt_snoop_cluster_chk #(
  .NCPU(NCPU), .AW(AW), .NSETS(NSETS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gnt_i        (bus_gnt),
  .req_ready_i  (req_ready_o),
  .rsp_valid_i  (rsp_valid_o),
  .line_valid_i (line_valid_o),
  .bus_valid_i  (bus_valid_o),
  .bus_we_i     (bus_we_o),
  .bus_addr_i   (bus_addr_o)
);

// File: tb/wt_snoop_cluster_tb.sv
`timescale 1ns/1ps
module wt_snoop_cluster_tb;
  localparam int NCPU = 3;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int NSETS = 2;

  typedef struct packed {
    logic [1:0]    cpu;
    logic [DW-1:0] data;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCPU-1:0]       req_valid = '0;
  logic [NCPU-1:0]       req_we = '0;
  logic [NCPU*AW-1:0]    req_addr = '0;
  logic [NCPU*DW-1:0]    req_wdata = '0;
  logic [NCPU-1:0]       req_ready;
  logic [NCPU-1:0]       rsp_valid;
  logic [NCPU*DW-1:0]    rsp_rdata;
  logic [NCPU*NSETS-1:0] line_valid;
  logic                  bus_valid, bus_we;
  logic [AW-1:0]         bus_addr;

  int n_chk = 0;
  int n_fail = 0;
  int bus_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;
  string cur_tag = "";
  item_t sb_q[$];

  always #5 clk = ~clk;

  wt_snoop_cluster u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_ready_o (req_ready),
    .req_we_i (req_we), .req_addr_i (req_addr), .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid), .rsp_rdata_o (rsp_rdata),
    .line_valid_o (line_valid),
    .bus_valid_o (bus_valid), .bus_we_o (bus_we), .bus_addr_o (bus_addr)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each response
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_valid) bus_cnt++;
      for (int k = 0; k < NCPU; k++) begin
        if (rsp_valid[k]) begin
          if (sb_q.size() == 0) begin
            check({cur_tag, " unexpected rsp cpu"}, k, -1);
          end else begin
            item_t it;
            it = sb_q.pop_front();
            check({cur_tag, " rsp cpu"}, k, int'(it.cpu));
            check({cur_tag, " rsp data"}, int'(rsp_rdata[k*DW +: DW]), int'(it.data));
          end
        end
      end
    end
  end

  task automatic send(int cpu, bit we, int addr, int wdata, int exp, string tag);
    item_t it;
    cur_tag = tag;
    it.cpu = 2'(cpu);
    it.data = DW'(exp);
    sb_q.push_back(it);
    @(negedge clk);
    req_valid[cpu] = 1'b1;
    req_we[cpu] = we;
    req_addr[cpu*AW +: AW] = AW'(addr);
    req_wdata[cpu*DW +: DW] = DW'(wdata);
    while (!req_ready[cpu]) @(negedge clk);
    @(negedge clk);
    req_valid[cpu] = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // send and check bus transaction count
  task automatic op(int cpu, bit we, int addr, int wdata, int exp, int exp_bus, string tag);
    int b0;
    b0 = bus_cnt;
    send(cpu, we, addr, wdata, exp, tag);
    check({tag, " bus transactions"}, bus_cnt - b0, exp_bus);
  endtask

  function automatic int lv(int cpu, int set);
    return int'(line_valid[cpu*NSETS + set]);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", int'(req_ready), 7);
    check("R1 lines", int'(line_valid), 0);
    check("R1 rsp", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", int'(req_ready), 7);

    // R2 read miss, R9 line index
    op(0, 0, 0, 0, 0, 1, "R2 cpu0 read a0 miss");
    check("R9 cpu0 set0 present", lv(0, 0), 1);
    check("R9 cpu0 set1 absent", lv(0, 1), 0);
    // R3 read hit
    op(0, 0, 0, 0, 0, 0, "R3 cpu0 read a0 hit");
    op(1, 0, 0, 0, 0, 1, "R2 cpu1 read a0 miss");
    op(2, 0, 0, 0, 0, 1, "R2 cpu2 read a0 miss");
    check("R2 all share a0", lv(0,0) + lv(1,0) + lv(2,0), 3);

    // R4/R5 write invalidates others
    op(0, 1, 0, 1, 1, 1, "R4 cpu0 write a0=1");
    check("R5 cpu1 a0 invalidated", lv(1, 0), 0);
    check("R5 cpu2 a0 invalidated", lv(2, 0), 0);
    check("R4 writer keeps a0", lv(0, 0), 1);
    op(0, 1, 0, 2, 2, 1, "R4 cpu0 write a0=2 no sharers");
    check("R5 writer still present", lv(0, 0), 1);
    op(0, 0, 0, 0, 2, 0, "R3 cpu0 read hit after write");
    op(1, 0, 0, 0, 2, 1, "R4 cpu1 sees write-through");

    // R6 tag mismatch in same set
    op(2, 0, 2, 0, 0, 1, "R6 cpu2 read a2 miss");
    op(0, 1, 0, 3, 3, 1, "R6 cpu0 write a0=3");
    check("R6 cpu2 a2 untouched", lv(2, 0), 1);
    check("R5 cpu1 a0 invalidated again", lv(1, 0), 0);
    op(2, 0, 2, 0, 0, 0, "R6 cpu2 read a2 still hits");

    // R7 replacement
    op(2, 0, 0, 0, 3, 1, "R7 cpu2 read a0 replaces a2");
    op(2, 0, 2, 0, 0, 1, "R7 cpu2 read a2 misses again");

    // R4 write miss allocate, R9 set1
    op(1, 1, 3, 4, 4, 1, "R4 cpu1 write miss a3=4");
    check("R9 cpu1 set1 present", lv(1, 1), 1);
    op(1, 0, 3, 0, 4, 0, "R4 cpu1 read a3 hits after allocate");

    // R8 simultaneous writes to a1
    begin
      item_t it;
      int b0;
      b0 = bus_cnt;
      cur_tag = "R8 burst";
      for (int k = 0; k < NCPU; k++) begin
        it.cpu = 2'(k);
        it.data = DW'(5 + k);
        sb_q.push_back(it);
      end
      @(negedge clk);
      for (int k = 0; k < NCPU; k++) begin
        req_valid[k] = 1'b1;
        req_we[k] = 1'b1;
        req_addr[k*AW +: AW] = AW'(1);
        req_wdata[k*DW +: DW] = DW'(5 + k);
      end
      @(negedge clk);
      req_valid = '0;
      check("R8 all busy in first bus cycle", int'(req_ready), 0);
      @(negedge clk);
      check("R8 cpu0 done first, others wait", int'(req_ready), 1);
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
      check("R8 bus transactions", bus_cnt - b0, 3);
      check("R8 cpu0 a1 invalidated", lv(0, 1), 0);
      check("R8 cpu1 a1 invalidated", lv(1, 1), 0);
      check("R8 cpu2 a1 present", lv(2, 1), 1);
    end
    op(0, 0, 1, 0, 7, 1, "R10 cpu0 read a1 gets last writer");
    check("R10 queue drained", sb_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule